// File: doc/BRIEF.md
# Ping-Pong Word Transfer Sequencer

This block paces the word transfers of one DMA channel and hands them, one at a time, to a simple data mover. Every word is offered on a valid/ready handshake together with a memory address, a peripheral address and a direction bit. The sequencer counts the words down from a programmed count. It reports where it stands through a busy flag, a remaining-count field, a ping-pong bit and one-cycle events.

There are two ways to run. In single-shot mode the channel moves one region of count+1 words, raises an end-of-count event and goes idle. In continuous mode the programmed count covers only half of a double buffer. Each half ends with its own event, and a ping-pong bit shows which half just completed. The channel does not stop at either point. At the end of each full buffer it wraps back to the pointers most recently written, so software can steer the next buffer without stopping the channel.

Pacing comes from two live inputs. With flow control on, a word is offered only while the peripheral asserts its request. A hold input stops new words from being offered and leaves the position where it is.

Back-pressure rules:
- Once `mv_valid_o` is high and `mv_ready_i` is low, the offer stays up with stable addresses until it is accepted. Hold, flow control and a dropped peripheral request do not withdraw it.
- Only a stop pulse withdraws an offer, and it does so in the same cycle.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, `busy_o`, `mv_valid_o`, `ping_o`, `rem_count_o`, `seg_bytes_o` and all three event outputs are 0.
- R2: In single-shot mode (`cfg_once_i`=1 at start) the channel accepts exactly `cfg_wcount_i`+1 words. It pulses `evt_eoc_o` once, and `busy_o` is 0 from that same cycle.
- R3: In continuous mode (`cfg_once_i`=0) `evt_eoc_o` pulses after every `cfg_wcount_i`+1 accepted words. The first, third, … such pulses come with `evt_half_o` and the second, fourth, … with `evt_full_o`. `busy_o` stays 1 until a stop.
- R4: An internal parity bit clears at start and toggles at every end-of-count. `ping_o` = parity XOR direction, where direction is latched from `cfg_dir_i` at start (0 = peripheral-to-memory, 1 = memory-to-peripheral). After the first half, `ping_o` is therefore 1 for peripheral-to-memory and 0 for memory-to-peripheral.
- R5: On each end-of-count, `seg_bytes_o` becomes (count+1)×4 for a single-shot region or a first half, and (count+1)×8 for a full buffer.
- R6: While busy, `rem_count_o` equals the words still to move in the current region or half, minus one. It reloads to the programmed count at each half boundary in continuous mode.
- R7: A `stop_i` pulse while busy makes `busy_o` 0 on the next cycle. `rem_count_o` keeps the value it had.
- R8: `ptr_we_i` writes `ptr_mem_i` and `ptr_per_i` into shadow pointers. At the start of each buffer (the start pulse, or the end of a full buffer in continuous mode) the active pointers are loaded from the shadows. The n-th word of a buffer (n from 0) uses memory address base+4n, and the peripheral address is fixed at its base.
- R9: With `cfg_flow_i`=1, a new word is offered only in a cycle where `per_req_i` is 1. Each such cycle accepted by the mover moves one word.
- R10: While `cfg_hold_i`=1, no new word is offered, and `rem_count_o` and `mv_mem_addr_o` stay unchanged.
- R11: `start_i` while busy is ignored. The count and the position are not reloaded.
- R12: While `mv_valid_o`=1 and `mv_ready_i`=0 with no stop, `mv_valid_o` stays 1 and `mv_mem_addr_o` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; latches mode, direction and count |
| stop_i | input | 1 | Stop pulse; ends the run early |
| cfg_once_i | input | 1 | 1 = single-shot, 0 = continuous double buffer |
| cfg_dir_i | input | 1 | 0 = peripheral-to-memory, 1 = memory-to-peripheral |
| cfg_flow_i | input | 1 | Pace words by the peripheral request |
| cfg_hold_i | input | 1 | Pause offering new words |
| cfg_wcount_i | input | CNT_W | Words per region (or per half) minus one |
| ptr_we_i | input | 1 | Write strobe for the shadow pointers |
| ptr_mem_i | input | AW | Memory base pointer |
| ptr_per_i | input | AW | Peripheral pointer |
| per_req_i | input | 1 | Peripheral transfer request |
| mv_valid_o | output | 1 | Word offer to the data mover |
| mv_ready_i | input | 1 | Data mover accepts the word |
| mv_mem_addr_o | output | AW | Memory address of the offered word |
| mv_per_addr_o | output | AW | Peripheral address of the offered word |
| mv_dir_o | output | 1 | Latched direction |
| busy_o | output | 1 | Channel running |
| rem_count_o | output | CNT_W | Remaining words in current region minus one |
| ping_o | output | 1 | Ping-pong half indicator |
| evt_eoc_o | output | 1 | End-of-count pulse |
| evt_half_o | output | 1 | First half of buffer done (continuous) |
| evt_full_o | output | 1 | Second half of buffer done (continuous) |
| seg_bytes_o | output | CNT_W+4 | Bytes completed at the last event |

## Verification
A table of vectors drives both modes with free-running acceptance. It covers a one-word count, small and mid-size counts, and both directions. This separates the single-shot stop from the continuous half/full alternation, and shows the ping-pong inversion by direction. Directed runs then withhold `mv_ready_i` and raise hold, to show that a pending offer is held while no new one appears. A sparse peripheral request pattern checks that flow control moves one word per request. A shadow pointer write in the middle of a buffer checks that it only affects the next buffer. A start pulse issued while running and an early stop show that the remaining count is neither reloaded nor lost.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/dmaseq_wordcnt.sv
module dmaseq_wordcnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] cfg_wc_i,
  input  logic             reload_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] wc_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] wc_q, rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q  <= '0;
      rem_q <= '0;
    end else if (ld_i) begin
      wc_q  <= cfg_wc_i;
      rem_q <= cfg_wc_i;
    end else if (reload_i) begin
      rem_q <= wc_q;
    end else if (dec_i) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign wc_o   = wc_q;
  assign rem_o  = rem_q;
  assign zero_o = (rem_q == '0);
endmodule

// File: rtl/dmaseq_ptrs.sv
module dmaseq_ptrs #(
  parameter int unsigned AW         = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] mem_i,
  input  logic [AW-1:0] per_i,
  input  logic          ld_i,
  input  logic          rl_i,
  input  logic          step_i,
  output logic [AW-1:0] mem_o,
  output logic [AW-1:0] per_o
);
  localparam int unsigned NPTR = 2;

  logic [AW-1:0] wr_val [NPTR];
  logic [AW-1:0] act    [NPTR];

  assign wr_val[0] = mem_i;
  assign wr_val[1] = per_i;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [AW-1:0] STEP = (g == 0) ? AW'(WORD_BYTES) : '0;
    logic [AW-1:0] shadow_q, act_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
      end else if (we_i) begin
        shadow_q <= wr_val[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= '0;
      end else if (ld_i || rl_i) begin
        act_q <= shadow_q;
      end else if (step_i) begin
        act_q <= act_q + STEP;
      end
    end

    assign act[g] = act_q;
  end

  assign mem_o = act[0];
  assign per_o = act[1];
endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned BYTES_W = CNT_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               cfg_once_i,
  input  logic               cfg_dir_i,
  input  logic               cfg_flow_i,
  input  logic               cfg_hold_i,
  input  logic               per_req_i,
  input  logic               mv_ready_i,
  input  logic               rem_zero_i,
  input  logic [CNT_W-1:0]   wc_i,
  output logic               busy_o,
  output logic               mv_valid_o,
  output logic               once_o,
  output logic               dir_o,
  output logic               pend_o,
  output logic               ld_o,
  output logic               rl_cnt_o,
  output logic               dec_o,
  output logic               buf_rl_o,
  output logic               step_o,
  output logic               ping_o,
  output logic               evt_eoc_o,
  output logic               evt_half_o,
  output logic               evt_full_o,
  output logic [BYTES_W-1:0] seg_bytes_o
);
  localparam int unsigned SH = $clog2(WORD_BYTES);

  phase_e phase_q;
  logic once_q, dir_q, pend_q, pp_q;
  logic eoc_q, half_q, full_q;
  logic [BYTES_W-1:0] seg_q;
  logic busy, go, offer, valid, hs, last;
  logic [BYTES_W-1:0] words, half_bytes, full_bytes;

  assign busy  = (phase_q != PH_IDLE);
  assign go    = start_i & ~busy;
  assign offer = ~cfg_hold_i & (~cfg_flow_i | per_req_i);
  assign valid = busy & ~stop_i & (pend_q | offer);
  assign hs    = valid & mv_ready_i;
  assign last  = hs & rem_zero_i;

  assign words      = {{(BYTES_W-CNT_W){1'b0}}, wc_i} + BYTES_W'(1);
  assign half_bytes = words << SH;
  assign full_bytes = words << (SH + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      once_q  <= 1'b0;
      dir_q   <= 1'b0;
      pend_q  <= 1'b0;
      pp_q    <= 1'b0;
      eoc_q   <= 1'b0;
      half_q  <= 1'b0;
      full_q  <= 1'b0;
      seg_q   <= '0;
    end else begin
      eoc_q  <= 1'b0;
      half_q <= 1'b0;
      full_q <= 1'b0;
      if (go) begin
        phase_q <= PH_LOW;
        once_q  <= cfg_once_i;
        dir_q   <= cfg_dir_i;
        pend_q  <= 1'b0;
        pp_q    <= 1'b0;
      end else if (busy && stop_i) begin
        phase_q <= PH_IDLE;
        pend_q  <= 1'b0;
      end else if (busy) begin
        pend_q <= valid & ~mv_ready_i;
        if (last) begin
          eoc_q <= 1'b1;
          pp_q  <= ~pp_q;
          if (once_q) begin
            phase_q <= PH_IDLE;
            seg_q   <= half_bytes;
          end else if (phase_q == PH_LOW) begin
            phase_q <= PH_HIGH;
            half_q  <= 1'b1;
            seg_q   <= half_bytes;
          end else begin
            phase_q <= PH_LOW;
            full_q  <= 1'b1;
            seg_q   <= full_bytes;
          end
        end
      end
    end
  end

  assign busy_o      = busy;
  assign mv_valid_o  = valid;
  assign once_o      = once_q;
  assign dir_o       = dir_q;
  assign pend_o      = pend_q;
  assign ld_o        = go;
  assign rl_cnt_o    = last & ~once_q;
  assign dec_o       = hs & ~rem_zero_i;
  assign buf_rl_o    = last & ~once_q & (phase_q == PH_HIGH);
  assign step_o      = hs & ~buf_rl_o;
  assign ping_o      = pp_q ^ dir_q;
  assign evt_eoc_o   = eoc_q;
  assign evt_half_o  = half_q;
  assign evt_full_o  = full_q;
  assign seg_bytes_o = seg_q;
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned AW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               cfg_once_i,
  input  logic               cfg_dir_i,
  input  logic               cfg_flow_i,
  input  logic               cfg_hold_i,
  input  logic [CNT_W-1:0]   cfg_wcount_i,
  input  logic               ptr_we_i,
  input  logic [AW-1:0]      ptr_mem_i,
  input  logic [AW-1:0]      ptr_per_i,
  input  logic               per_req_i,
  output logic               mv_valid_o,
  input  logic               mv_ready_i,
  output logic [AW-1:0]      mv_mem_addr_o,
  output logic [AW-1:0]      mv_per_addr_o,
  output logic               mv_dir_o,
  output logic               busy_o,
  output logic [CNT_W-1:0]   rem_count_o,
  output logic               ping_o,
  output logic               evt_eoc_o,
  output logic               evt_half_o,
  output logic               evt_full_o,
  output logic [CNT_W+3:0]   seg_bytes_o
);
  localparam int unsigned BYTES_W = CNT_W + 4;

  logic             rem_zero, once_w, pend_w;
  logic             ld, rl_cnt, dec, buf_rl, step;
  logic [CNT_W-1:0] wc_w;

  dmaseq_ctrl #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .cfg_once_i  (cfg_once_i),
    .cfg_dir_i   (cfg_dir_i),
    .cfg_flow_i  (cfg_flow_i),
    .cfg_hold_i  (cfg_hold_i),
    .per_req_i   (per_req_i),
    .mv_ready_i  (mv_ready_i),
    .rem_zero_i  (rem_zero),
    .wc_i        (wc_w),
    .busy_o      (busy_o),
    .mv_valid_o  (mv_valid_o),
    .once_o      (once_w),
    .dir_o       (mv_dir_o),
    .pend_o      (pend_w),
    .ld_o        (ld),
    .rl_cnt_o    (rl_cnt),
    .dec_o       (dec),
    .buf_rl_o    (buf_rl),
    .step_o      (step),
    .ping_o      (ping_o),
    .evt_eoc_o   (evt_eoc_o),
    .evt_half_o  (evt_half_o),
    .evt_full_o  (evt_full_o),
    .seg_bytes_o (seg_bytes_o)
  );

  dmaseq_wordcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (ld),
    .cfg_wc_i (cfg_wcount_i),
    .reload_i (rl_cnt),
    .dec_i    (dec),
    .wc_o     (wc_w),
    .rem_o    (rem_count_o),
    .zero_o   (rem_zero)
  );

  dmaseq_ptrs #(.AW(AW), .WORD_BYTES(dmaseq_pkg::WORD_BYTES)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (ptr_we_i),
    .mem_i  (ptr_mem_i),
    .per_i  (ptr_per_i),
    .ld_i   (ld),
    .rl_i   (buf_rl),
    .step_i (step),
    .mem_o  (mv_mem_addr_o),
    .per_o  (mv_per_addr_o)
  );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop,
  input logic             flow,
  input logic             hold,
  input logic             preq,
  input logic             valid,
  input logic             ready,
  input logic [AW-1:0]    maddr,
  input logic             busy,
  input logic [CNT_W-1:0] rem,
  input logic             ping,
  input logic             eoc,
  input logic             half,
  input logic             full,
  input logic             once_st,
  input logic             pend_st
);
  assert_once_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc && once_st |-> !busy);

  assert_half_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> busy && eoc);

  assert_half_full_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({half, full}));

  assert_ping_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> ping != $past(ping));

  assert_rem_decrements_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && valid && ready && rem != '0 |=> rem == CNT_W'($past(rem) - 1'b1));

  assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stop |=> !busy);

  assert_flow_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && flow && !pend_st |-> preq);

  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hold && !valid |=> $stable(rem) && $stable(maddr));

  assert_offer_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !stop |=> (valid || stop) && $stable(maddr));
endmodule

bind dmaseq_top dmaseq_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stop    (stop_i),
  .flow    (cfg_flow_i),
  .hold    (cfg_hold_i),
  .preq    (per_req_i),
  .valid   (mv_valid_o),
  .ready   (mv_ready_i),
  .maddr   (mv_mem_addr_o),
  .busy    (busy_o),
  .rem     (rem_count_o),
  .ping    (ping_o),
  .eoc     (evt_eoc_o),
  .half    (evt_half_o),
  .full    (evt_full_o),
  .once_st (once_w),
  .pend_st (pend_w)
);

// File: tb/tb_dmaseq_top.sv
`timescale 1ns/1ps
module tb_dmaseq_top;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned AW    = 32;
  localparam logic [AW-1:0] PER_BASE = 32'h0000_4400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, cfg_once_i = 0, cfg_dir_i = 0;
  logic cfg_flow_i = 0, cfg_hold_i = 0, ptr_we_i = 0, per_req_i = 0, mv_ready_i = 0;
  logic [CNT_W-1:0] cfg_wcount_i = '0;
  logic [AW-1:0] ptr_mem_i = '0, ptr_per_i = '0;
  logic mv_valid_o, mv_dir_o, busy_o, ping_o, evt_eoc_o, evt_half_o, evt_full_o;
  logic [AW-1:0] mv_mem_addr_o, mv_per_addr_o;
  logic [CNT_W-1:0] rem_count_o;
  logic [CNT_W+3:0] seg_bytes_o;

  always #5 clk = ~clk;

  dmaseq_top #(.CNT_W(CNT_W), .AW(AW)) dut (.*);

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int hs_cnt, eoc_cnt, half_cnt, full_cnt, addr_bad, flow_bad;
  longint last_bytes, second_first_addr;
  logic ping_half, ping_full;
  int nbuf, buf_idx, buf_words;
  logic [AW-1:0] cur_base, next_base;

  // vector: {once, dir, wcount}
  localparam logic [9:0] VECS [6] = '{
    {1'b1, 1'b0, 8'd0}, {1'b1, 1'b1, 8'd5}, {1'b0, 1'b0, 8'd0},
    {1'b0, 1'b1, 8'd3}, {1'b0, 1'b0, 8'd6}, {1'b1, 1'b0, 8'd15}
  };

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick_a();
    @(negedge clk);
    cyc++;
    if (evt_eoc_o) begin eoc_cnt++; last_bytes = seg_bytes_o; end
    if (evt_half_o) begin half_cnt++; if (half_cnt == 1) ping_half = ping_o; end
    if (evt_full_o) begin full_cnt++; ping_full = ping_o; end
  endtask

  task automatic tick_b();
    #1;
    if (mv_valid_o && mv_ready_i) begin
      hs_cnt++;
      if (cfg_flow_i && !per_req_i) flow_bad++;
      if (mv_mem_addr_o != cur_base + AW'(4 * nbuf)) addr_bad++;
      if (mv_per_addr_o != PER_BASE) addr_bad++;
      if (nbuf == 0 && buf_idx == 1) second_first_addr = mv_mem_addr_o;
      nbuf++;
      if (nbuf == buf_words) begin
        nbuf = 0; cur_base = next_base; buf_idx++;
      end
    end
  endtask

  task automatic setup(input logic once, input logic dir, input int wc, input logic [AW-1:0] base);
    tick_a();
    cfg_once_i = once; cfg_dir_i = dir; cfg_wcount_i = CNT_W'(wc);
    ptr_mem_i = base; ptr_per_i = PER_BASE; ptr_we_i = 1'b1; mv_ready_i = 1'b1;
    tick_b();
    tick_a(); ptr_we_i = 1'b0; tick_b();
    hs_cnt = 0; eoc_cnt = 0; half_cnt = 0; full_cnt = 0; addr_bad = 0; flow_bad = 0;
    last_bytes = 0; second_first_addr = 0; ping_half = 0; ping_full = 0;
    nbuf = 0; buf_idx = 0; cur_base = base; next_base = base;
    buf_words = once ? wc + 1 : 2 * (wc + 1);
    tick_a(); start_i = 1'b1; tick_b();
    tick_a(); start_i = 1'b0; tick_b();
  endtask

  task automatic stop_now();
    tick_a(); stop_i = 1'b1; tick_b();
    tick_a(); stop_i = 1'b0; tick_b();
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy_o, 0);
    chk("R1", "valid", mv_valid_o, 0);
    chk("R1", "ping", ping_o, 0);
    chk("R1", "rem", rem_count_o, 0);
    chk("R1", "events", {evt_eoc_o, evt_half_o, evt_full_o}, 0);
    chk("R1", "seg_bytes", seg_bytes_o, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      automatic logic once = VECS[v][9];
      automatic logic dir  = VECS[v][8];
      automatic int   wc   = int'(VECS[v][7:0]);
      automatic int   guard = 0;
      setup(once, dir, wc, 32'h0001_0000 + 32'(v) * 32'h100);
      forever begin
        tick_a();
        guard++;
        if (guard > 5000) begin chk("R3", "run timeout", guard, 0); break; end
        if (once && !busy_o) break;
        if (!once && full_cnt == 2) begin
          stop_i = 1'b1; tick_b();
          tick_a(); stop_i = 1'b0;
          break;
        end
        tick_b();
      end
      chk(once ? "R2" : "R7", "busy after run", busy_o, 0);
      chk("R8", "address errors", addr_bad, 0);
      if (once) begin
        chk("R2", "words", hs_cnt, wc + 1);
        chk("R2", "eoc pulses", eoc_cnt, 1);
        chk("R5", "bytes single", last_bytes, (wc + 1) * 4);
      end else begin
        chk("R3", "words", hs_cnt, 4 * (wc + 1));
        chk("R3", "eoc pulses", eoc_cnt, 4);
        chk("R3", "half events", half_cnt, 2);
        chk("R3", "full events", full_cnt, 2);
        chk("R5", "bytes full", last_bytes, (wc + 1) * 8);
        chk("R4", "ping at half", ping_half, 1 ^ dir);
        chk("R4", "ping at full", ping_full, dir);
      end
      tick_b();
    end

    // R6 R10 R11 R12 R7: directed single-shot run with back-pressure
    begin
      automatic logic [AW-1:0] held_addr;
      automatic int bad = 0;
      setup(1'b1, 1'b0, 9, 32'h0002_0000);
      repeat (2) begin tick_a(); tick_b(); end
      tick_a(); mv_ready_i = 1'b0; tick_b();
      chk("R12", "offer up", mv_valid_o, 1);
      held_addr = mv_mem_addr_o;
      tick_a(); cfg_hold_i = 1'b1; tick_b();
      repeat (3) begin
        tick_a(); tick_b();
        if (!mv_valid_o || mv_mem_addr_o != held_addr) bad++;
      end
      chk("R12", "offer withdrawn or moved", bad, 0);
      tick_a(); mv_ready_i = 1'b1; tick_b();
      chk("R12", "words after pending accept", hs_cnt, 4);
      bad = 0;
      repeat (4) begin
        tick_a(); tick_b();
        if (mv_valid_o) bad++;
      end
      chk("R10", "offers while held", bad, 0);
      tick_a();
      chk("R6", "rem after words", rem_count_o, 9 - hs_cnt);
      cfg_wcount_i = CNT_W'(20); start_i = 1'b1; tick_b();
      tick_a(); start_i = 1'b0;
      chk("R11", "rem after restart", rem_count_o, 9 - hs_cnt);
      chk("R11", "busy after restart", busy_o, 1);
      chk("R10", "addr under hold", mv_mem_addr_o, 32'h0002_0000 + 32'(4 * hs_cnt));
      tick_b();
      stop_now();
      chk("R7", "busy after stop", busy_o, 0);
      chk("R7", "rem after stop", rem_count_o, 9 - hs_cnt);
      cfg_hold_i = 1'b0;
    end

    // R9 flow control with a sparse request
    begin
      automatic int guard = 0;
      cfg_flow_i = 1'b1;
      setup(1'b1, 1'b1, 7, 32'h0003_0000);
      forever begin
        tick_a();
        guard++;
        if (!busy_o || guard > 5000) break;
        per_req_i = (cyc % 3 == 0);
        tick_b();
      end
      per_req_i = 1'b0; cfg_flow_i = 1'b0;
      chk("R9", "words", hs_cnt, 8);
      chk("R9", "words without request", flow_bad, 0);
      chk("R2", "eoc pulses flow", eoc_cnt, 1);
      tick_b();
    end

    // R8 shadow pointer written mid-buffer applies to next buffer
    begin
      automatic int guard = 0;
      automatic bit wrote = 0;
      setup(1'b0, 1'b0, 3, 32'h0000_1000);
      forever begin
        tick_a();
        guard++;
        ptr_we_i = 1'b0;
        if (guard > 5000) break;
        if (full_cnt == 2) begin
          stop_i = 1'b1; tick_b();
          tick_a(); stop_i = 1'b0;
          break;
        end
        if (!wrote && hs_cnt == 2) begin
          wrote = 1; ptr_we_i = 1'b1; ptr_mem_i = 32'h0000_8000; next_base = 32'h0000_8000;
        end
        tick_b();
      end
      chk("R8", "address errors", addr_bad, 0);
      chk("R8", "second buffer start", second_first_addr, 32'h0000_8000);
      chk("R6", "rem reload at half", rem_count_o, 3);
      tick_b();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule